// File: doc/BRIEF.md
# Redundant Store Output Comparator

This block guards the exit of a region in which a program runs twice, as a leading copy and a trailing copy. Every store that either copy commits goes into a queue that belongs to that copy alone. The two copies are not in lockstep, so one copy's store can arrive many cycles before the matching store from the other. The block keeps each store until its twin is present. It then checks the twin against it and sends the store on to the data cache only if the two agree.

Uncached load addresses also leave the region, so they are checked in the same way. Each copy has a one-entry slot for them, and an address goes out only when both slots hold the same value. Register results stay inside the region and are never seen here. The first disagreement of either kind sets a fault flag. That flag stays set, and it stops all traffic out of the block until reset, so a corrupted write can never reach memory.

Top module: `redundant_store_checker`

## Requirements
- R1: Stores are paired in program order. The oldest queued leading store is always compared with the oldest queued trailing store, and released stores leave in the order the leading copy enqueued them.
- R2: A pair is released only when both its address and its data are bit-for-bit equal. The release raises `mem_st_valid` for one cycle, carrying the leading copy's address and data, one clock edge after both copies sit at the heads of their queues.
- R3: A store whose twin has not yet arrived is held for as long as it takes, and nothing is released in that time.
- R4: Each copy has its own queue of `DEPTH` entries. A copy's ready output goes low only when its own queue is full, whatever the other queue holds.
- R5: A difference in any single address or data bit between the two copies of a store sets `fault` at the next clock edge, and that pair is never released.
- R6: `fault` is sticky until reset. While it is set, no store and no uncached load address is released.
- R7: An uncached load address from each copy is held in a one-entry slot for that copy, with ready low while the slot is occupied. When both slots are full and hold equal addresses, the address appears on `mem_ld_addr` with `mem_ld_valid` high for one cycle. If the two addresses differ, `fault` is set and nothing is released.
- R8: After reset, `fault`, `mem_st_valid` and `mem_ld_valid` are low and all four enqueue ready outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lead_st_valid | input | 1 | Leading copy offers a committed store |
| lead_st_ready | output | 1 | Leading store queue has room |
| lead_st_addr | input | 32 | Leading store address |
| lead_st_data | input | 32 | Leading store data |
| trail_st_valid | input | 1 | Trailing copy offers a committed store |
| trail_st_ready | output | 1 | Trailing store queue has room |
| trail_st_addr | input | 32 | Trailing store address |
| trail_st_data | input | 32 | Trailing store data |
| lead_ld_valid | input | 1 | Leading copy offers an uncached load address |
| lead_ld_ready | output | 1 | Leading load slot is empty |
| lead_ld_addr | input | 32 | Leading uncached load address |
| trail_ld_valid | input | 1 | Trailing copy offers an uncached load address |
| trail_ld_ready | output | 1 | Trailing load slot is empty |
| trail_ld_addr | input | 32 | Trailing uncached load address |
| mem_st_valid | output | 1 | Checked store released to the data cache |
| mem_st_addr | output | 32 | Released store address |
| mem_st_data | output | 32 | Released store data |
| mem_ld_valid | output | 1 | Checked uncached load address released |
| mem_ld_addr | output | 32 | Released uncached load address |
| fault | output | 1 | Sticky mismatch indication |

## Verification
The assertions assume that a copy holds its valid, address and data steady while ready is low. They also assume that both copies offer their stores and uncached loads in the same program order, so that each queue head really has its twin at the other queue's head. The bench drives each offer at the falling edge and keeps it there until ready is seen high. It lets only the trailing copy's values differ, and only by one flipped bit, so every fault it causes comes from a real mismatch and never from pairs that are out of order.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
    localparam int unsigned RSC_ADDR_W  = 32;
    localparam int unsigned RSC_DATA_W  = 32;
    localparam int unsigned RSC_THREADS = 2;

    typedef struct packed {
        logic [RSC_ADDR_W-1:0] addr;
        logic [RSC_DATA_W-1:0] data;
    } rsc_store_t;

    typedef struct packed {
        logic                                    fault;
        logic                                    st_out_valid;
        rsc_store_t                              st_out;
        logic                                    ld_out_valid;
        logic [RSC_ADDR_W-1:0]                   ld_out_addr;
        logic [RSC_THREADS-1:0]                  ldh_valid;
        logic [RSC_THREADS-1:0][RSC_ADDR_W-1:0]  ldh_addr;
    } rsc_state_t;
endpackage

// File: rtl/rsc_queue.sv
module rsc_queue #(
    parameter int unsigned W     = 64,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_valid,
    output logic         push_ready,
    input  logic [W-1:0] push_item,
    output logic         head_valid,
    output logic [W-1:0] head_item,
    input  logic         pop
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } qptr_t;

    qptr_t      ptr_d, ptr_q;
    logic [W-1:0] slots_q [DEPTH];
    logic       do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign push_ready = (ptr_q.cnt != CNT_W'(DEPTH));
    assign head_valid = (ptr_q.cnt != '0);
    assign head_item  = slots_q[ptr_q.rd];
    assign do_push    = push_valid && push_ready;
    assign do_pop     = pop && head_valid;

    always_comb begin
        ptr_d = ptr_q;
        if (do_push) ptr_d.wr = bump(ptr_q.wr);
        if (do_pop)  ptr_d.rd = bump(ptr_q.rd);
        ptr_d.cnt = ptr_q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) slots_q[ptr_q.wr] <= push_item;
    end

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !push_ready |=> (ptr_q.cnt <= $past(ptr_q.cnt)));
    assert_pop_nonempty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_valid);
endmodule

// File: rtl/rsc_match.sv
module rsc_match #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         same
);
    assign same = ~|(a ^ b);
endmodule

// File: rtl/redundant_store_checker.sv
module redundant_store_checker
    import rsc_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lead_st_valid,
    output logic                  lead_st_ready,
    input  logic [RSC_ADDR_W-1:0] lead_st_addr,
    input  logic [RSC_DATA_W-1:0] lead_st_data,
    input  logic                  trail_st_valid,
    output logic                  trail_st_ready,
    input  logic [RSC_ADDR_W-1:0] trail_st_addr,
    input  logic [RSC_DATA_W-1:0] trail_st_data,
    input  logic                  lead_ld_valid,
    output logic                  lead_ld_ready,
    input  logic [RSC_ADDR_W-1:0] lead_ld_addr,
    input  logic                  trail_ld_valid,
    output logic                  trail_ld_ready,
    input  logic [RSC_ADDR_W-1:0] trail_ld_addr,
    output logic                  mem_st_valid,
    output logic [RSC_ADDR_W-1:0] mem_st_addr,
    output logic [RSC_DATA_W-1:0] mem_st_data,
    output logic                  mem_ld_valid,
    output logic [RSC_ADDR_W-1:0] mem_ld_addr,
    output logic                  fault
);
    localparam int unsigned SW = RSC_ADDR_W + RSC_DATA_W;
    localparam int unsigned NT = RSC_THREADS;

    rsc_state_t st_d, st_q;

    logic [NT-1:0]          push_v, push_r, head_v;
    rsc_store_t [NT-1:0]    push_it, head_it;
    logic                   pop_both;
    logic                   st_same, ld_same;
    logic [NT-1:0]          ld_in_v;
    logic [NT-1:0][RSC_ADDR_W-1:0] ld_in_a;

    assign push_v     = {trail_st_valid, lead_st_valid};
    assign push_it[0] = '{addr: lead_st_addr,  data: lead_st_data};
    assign push_it[1] = '{addr: trail_st_addr, data: trail_st_data};
    assign ld_in_v    = {trail_ld_valid, lead_ld_valid};
    assign ld_in_a[0] = lead_ld_addr;
    assign ld_in_a[1] = trail_ld_addr;

    for (genvar t = 0; t < NT; t++) begin : g_queue
        rsc_queue #(.W(SW), .DEPTH(DEPTH)) i_queue (
            .clk        (clk),
            .rst_n      (rst_n),
            .push_valid (push_v[t]),
            .push_ready (push_r[t]),
            .push_item  (push_it[t]),
            .head_valid (head_v[t]),
            .head_item  (head_it[t]),
            .pop        (pop_both)
        );
    end

    rsc_match #(.W(SW)) i_st_match (
        .a    (head_it[0]),
        .b    (head_it[1]),
        .same (st_same)
    );

    rsc_match #(.W(RSC_ADDR_W)) i_ld_match (
        .a    (st_q.ldh_addr[0]),
        .b    (st_q.ldh_addr[1]),
        .same (ld_same)
    );

    logic st_pair, ld_pair;
    assign st_pair  = &head_v;
    assign ld_pair  = &st_q.ldh_valid;
    assign pop_both = st_pair && st_same && !st_q.fault;

    always_comb begin
        st_d              = st_q;
        st_d.st_out_valid = pop_both;
        if (pop_both) st_d.st_out = head_it[0];
        st_d.ld_out_valid = 1'b0;
        if (ld_pair && !st_q.fault && ld_same) begin
            st_d.ld_out_valid = 1'b1;
            st_d.ld_out_addr  = st_q.ldh_addr[0];
            st_d.ldh_valid    = '0;
        end
        for (int t = 0; t < NT; t++) begin
            if (ld_in_v[t] && !st_q.ldh_valid[t]) begin
                st_d.ldh_valid[t] = 1'b1;
                st_d.ldh_addr[t]  = ld_in_a[t];
            end
        end
        if ((st_pair && !st_same) || (ld_pair && !ld_same)) st_d.fault = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lead_st_ready  = push_r[0];
    assign trail_st_ready = push_r[1];
    assign lead_ld_ready  = !st_q.ldh_valid[0];
    assign trail_ld_ready = !st_q.ldh_valid[1];
    assign mem_st_valid   = st_q.st_out_valid;
    assign mem_st_addr    = st_q.st_out.addr;
    assign mem_st_data    = st_q.st_out.data;
    assign mem_ld_valid   = st_q.ld_out_valid;
    assign mem_ld_addr    = st_q.ld_out_addr;
    assign fault          = st_q.fault;

    assert_fault_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);
    assert_no_release_after_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (!mem_st_valid && !mem_ld_valid));
    assert_release_paired_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_st_valid |-> $past(head_v[0] && head_v[1]));
    assert_release_matched_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_st_valid |-> $past(st_same));
    assert_mismatch_faults_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_pair && !st_same) |=> (fault && !mem_st_valid));
    assert_ld_release_checked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ld_valid |-> $past(ld_pair && ld_same));
endmodule

// File: tb/test_redundant_store_checker.sv
module test_redundant_store_checker;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lead_st_valid = 0, trail_st_valid = 0;
    logic        lead_st_ready, trail_st_ready;
    logic [31:0] lead_st_addr = 0, lead_st_data = 0, trail_st_addr = 0, trail_st_data = 0;
    logic        lead_ld_valid = 0, trail_ld_valid = 0;
    logic        lead_ld_ready, trail_ld_ready;
    logic [31:0] lead_ld_addr = 0, trail_ld_addr = 0;
    logic        mem_st_valid, mem_ld_valid, fault;
    logic [31:0] mem_st_addr, mem_st_data, mem_ld_addr;

    int n_chk = 0, n_bad = 0;
    int st_n = 0, ld_n = 0;
    logic [31:0] st_a [64];
    logic [31:0] st_dv [64];
    logic [31:0] ld_a [64];

    always #2 clk = ~clk;

    redundant_store_checker #(.DEPTH(DEPTH)) i_redundant_store_checker (
        .clk(clk), .rst_n(rst_n),
        .lead_st_valid(lead_st_valid), .lead_st_ready(lead_st_ready),
        .lead_st_addr(lead_st_addr), .lead_st_data(lead_st_data),
        .trail_st_valid(trail_st_valid), .trail_st_ready(trail_st_ready),
        .trail_st_addr(trail_st_addr), .trail_st_data(trail_st_data),
        .lead_ld_valid(lead_ld_valid), .lead_ld_ready(lead_ld_ready), .lead_ld_addr(lead_ld_addr),
        .trail_ld_valid(trail_ld_valid), .trail_ld_ready(trail_ld_ready), .trail_ld_addr(trail_ld_addr),
        .mem_st_valid(mem_st_valid), .mem_st_addr(mem_st_addr), .mem_st_data(mem_st_data),
        .mem_ld_valid(mem_ld_valid), .mem_ld_addr(mem_ld_addr), .fault(fault)
    );

    always @(negedge clk) begin
        if (rst_n && mem_st_valid && st_n < 64) begin
            st_a[st_n]  = mem_st_addr;
            st_dv[st_n] = mem_st_data;
            st_n++;
        end
        if (rst_n && mem_ld_valid && ld_n < 64) begin
            ld_a[ld_n] = mem_ld_addr;
            ld_n++;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        st_n = 0;
        ld_n = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_st(input bit trail, input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        if (!trail) begin
            while (!lead_st_ready) @(negedge clk);
            lead_st_valid = 1; lead_st_addr = a; lead_st_data = d;
            @(negedge clk);
            lead_st_valid = 0;
        end else begin
            while (!trail_st_ready) @(negedge clk);
            trail_st_valid = 1; trail_st_addr = a; trail_st_data = d;
            @(negedge clk);
            trail_st_valid = 0;
        end
    endtask

    task automatic push_ld(input bit trail, input logic [31:0] a);
        @(negedge clk);
        if (!trail) begin
            while (!lead_ld_ready) @(negedge clk);
            lead_ld_valid = 1; lead_ld_addr = a;
            @(negedge clk);
            lead_ld_valid = 0;
        end else begin
            while (!trail_ld_ready) @(negedge clk);
            trail_ld_valid = 1; trail_ld_addr = a;
            @(negedge clk);
            trail_ld_valid = 0;
        end
    endtask

    task automatic t_reset();
        do_reset();
        check(!fault, "R8 fault", 64'(fault), 0);
        check(!mem_st_valid && !mem_ld_valid, "R8 release", 64'({mem_st_valid, mem_ld_valid}), 0);
        check(lead_st_ready && trail_st_ready && lead_ld_ready && trail_ld_ready, "R8 ready",
              64'({lead_st_ready, trail_st_ready, lead_ld_ready, trail_ld_ready}), 64'hf);
    endtask

    task automatic t_in_order();
        do_reset();
        for (int i = 0; i < 3; i++) push_st(0, 32'h1000 + 32'(i * 4), 32'hA0 + 32'(i));
        for (int i = 0; i < 3; i++) push_st(1, 32'h1000 + 32'(i * 4), 32'hA0 + 32'(i));
        idle(4);
        check(st_n == 3, "R1 count", 64'(st_n), 3);
        for (int i = 0; i < 3; i++) begin
            check(st_a[i] == 32'h1000 + 32'(i * 4), "R1 order addr", 64'(st_a[i]), 64'(32'h1000 + 32'(i * 4)));
            check(st_dv[i] == 32'hA0 + 32'(i), "R2 data", 64'(st_dv[i]), 64'(32'hA0 + 32'(i)));
        end
        check(!fault, "R2 no fault", 64'(fault), 0);
    endtask

    task automatic t_skew();
        do_reset();
        push_st(0, 32'h2000, 32'h55);
        idle(12);
        check(st_n == 0, "R3 held", 64'(st_n), 0);
        push_st(1, 32'h2000, 32'h55);
        idle(3);
        check(st_n == 1, "R3 released", 64'(st_n), 1);
    endtask

    task automatic t_backpressure();
        do_reset();
        for (int i = 0; i < DEPTH; i++) push_st(0, 32'h3000 + 32'(i), 32'(i));
        check(!lead_st_ready, "R4 lead full", 64'(lead_st_ready), 0);
        check(trail_st_ready, "R4 trail free", 64'(trail_st_ready), 1);
        check(st_n == 0, "R4 nothing out", 64'(st_n), 0);
        for (int i = 0; i < DEPTH; i++) push_st(1, 32'h3000 + 32'(i), 32'(i));
        idle(4);
        check(st_n == DEPTH, "R4 drained", 64'(st_n), 64'(DEPTH));
        check(lead_st_ready, "R4 lead ready again", 64'(lead_st_ready), 1);
    endtask

    task automatic t_flip(input bit on_addr, input int b);
        do_reset();
        push_st(0, 32'h4000, 32'h11); push_st(1, 32'h4000, 32'h11);
        push_st(0, 32'h4004, 32'h22);
        if (on_addr) push_st(1, 32'h4004 ^ (32'h1 << b), 32'h22);
        else         push_st(1, 32'h4004, 32'h22 ^ (32'h1 << b));
        idle(3);
        check(fault, "R5 fault on flip", 64'(fault), 1);
        check(st_n == 1, "R5 bad pair held", 64'(st_n), 1);
        push_st(0, 32'h4008, 32'h33); push_st(1, 32'h4008, 32'h33);
        push_ld(0, 32'h9000); push_ld(1, 32'h9000);
        idle(4);
        check(fault, "R6 sticky", 64'(fault), 1);
        check(st_n == 1, "R6 stores blocked", 64'(st_n), 1);
        check(ld_n == 0, "R6 loads blocked", 64'(ld_n), 0);
    endtask

    task automatic t_uncached();
        do_reset();
        push_ld(0, 32'h8000_0040);
        idle(5);
        check(ld_n == 0 && !lead_ld_ready, "R7 wait twin", 64'({ld_n[7:0], lead_ld_ready}), 0);
        push_ld(1, 32'h8000_0040);
        idle(3);
        check(ld_n == 1, "R7 released", 64'(ld_n), 1);
        check(ld_a[0] == 32'h8000_0040, "R7 addr", 64'(ld_a[0]), 64'h8000_0040);
        check(!fault && lead_ld_ready, "R7 no fault", 64'({fault, lead_ld_ready}), 1);
        push_ld(0, 32'h8000_0080); push_ld(1, 32'h8000_0081);
        idle(3);
        check(fault, "R7 mismatch fault", 64'(fault), 1);
        check(ld_n == 1, "R7 bad addr held", 64'(ld_n), 1);
    endtask

    initial begin
        t_reset();
        t_in_order();
        t_skew();
        t_backpressure();
        t_flip(0, 0);
        t_flip(0, 31);
        t_flip(1, 2);
        t_uncached();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule